// File: doc/BRIEF.md
# Stepped Soft-Start Reference Sequencer

This block produces the 5-bit step index that sets the feedback target of a boost LED driver. It also produces the millivolt value of that index, taken from a fixed pseudo-logarithmic table. When the run enable rises, the index starts at zero. It then climbs one step per fixed interval until it meets the target. While this start-up ramp runs, a soft-start flag is high, and a select that halves the switch current limit is high with it.

Once the ramp is over, the index follows the active target with one cycle of delay. The target comes from one of two sources, chosen by a mode flag:
- **Serial mode:** a stored code written through a code/strobe pair.
- **Duty mode:** a code derived from measured PWM duty. Each duty sample is a percentage, one per PWM period. Four samples are averaged, and the result is converted to the highest table step whose millivolt value does not exceed the duty times 200 mV.

Dropping the run enable is a shutdown. It clears the index and the ramp, and it restores both target sources to full scale.

Top module: `softstart_ref_seq`

## Requirements
- R1: While reset is low or run enable is low, step_idx is 0 and ss_active and ilim_half are 0; the stored serial code and the duty code both return to 31.
- R2: On the first clock edge with run enable high after it was low, the ramp starts at index 0. While ramping, the index rises by exactly one after every STEP_CYCLES clock cycles and holds in between.
- R3: ss_active and ilim_half are high for the whole ramp. Both drop on the same edge that makes step_idx equal to the target.
- R4: With no code programmed since the last shutdown, the ramp ends at code 31, so ref_mv is 200.
- R5: ref_mv follows step_idx through this table: code 0 is 0 mV; codes 1 to 12 are 3*code+2 mV; codes 13 to 23 are 38+6*(code-12) mV; codes 24 to 31 are 104+12*(code-23) mV.
- R6: After the ramp, in serial mode, a code written with prog_valid (taken only while run enable is high) appears on step_idx two edges after the strobe edge.
- R7: A code written during the ramp does not restart it. A higher target makes the ramp continue stepping up to it. A target at or below the current index ends the ramp on the next edge, with step_idx set to that target.
- R8: In duty mode, each group of four duty_valid samples is summed and divided by four (rounded down) to give the average A. The target becomes the highest code whose table value is at most 2*A mV. step_idx shows it one edge after the fourth sample.
- R9: Duty samples above 100 count as 100. An average below 1% gives code 0, and an average of 100% gives code 31.
- R10: A shutdown discards any programmed code, so the next enable ramps to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Run enable; low means shutdown |
| mode_serial | input | 1 | 1: stored serial code is the target; 0: duty-derived code |
| prog_code | input | 5 | Serially received step code |
| prog_valid | input | 1 | One-cycle strobe that stores prog_code |
| duty_pct | input | 8 | Measured duty of one PWM period, in percent |
| duty_valid | input | 1 | One-cycle strobe per measured period |
| step_idx | output | 5 | Current reference step index |
| ref_mv | output | 8 | Millivolt value of step_idx |
| ss_active | output | 1 | Soft-start ramp in progress |
| ilim_half | output | 1 | Select half switch current limit |

## Verification
The ramp is run three ways:
- To the default full-scale target, which confirms the step pacing and the timing of the flag drop.
- With a higher code written mid-ramp, which separates continuing from restarting.
- With a code below the current index, which shows the ramp ending early.

A sweep of all 32 serial codes after the ramp checks every table entry. Duty groups with equal samples, unequal samples, sub-1% values, over-range values and a value just reaching step 1 exercise the averaging, clamping and table search separately. A shutdown after programming shows that the stored code is discarded.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
  localparam int CODE_W   = 5;
  localparam int MV_W     = 8;
  localparam int N_CODES  = 1 << CODE_W;
  localparam logic [CODE_W-1:0] CODE_FULL = '1;

  // Piecewise table: coarse steps grow with level for a log-like curve.
  function automatic logic [MV_W-1:0] code_to_mv(input logic [CODE_W-1:0] c);
    int ci;
    int mv;
    ci = int'(c);
    if (ci == 0)       mv = 0;
    else if (ci <= 12) mv = 3 * ci + 2;
    else if (ci <= 23) mv = 38 + 6 * (ci - 12);
    else               mv = 104 + 12 * (ci - 23);
    return MV_W'(mv);
  endfunction

  // Highest code whose table value does not exceed mv.
  function automatic logic [CODE_W-1:0] mv_to_code(input logic [MV_W-1:0] mv);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int c = 0; c < N_CODES; c++) begin
      if (code_to_mv(CODE_W'(c)) <= mv) r = CODE_W'(c);
    end
    return r;
  endfunction
endpackage

// File: rtl/ssr_code_store.sv
`timescale 1ns/1ps
module ssr_code_store
  import ssr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [CODE_W-1:0] prog_code,
  input  logic              prog_valid,
  output logic [CODE_W-1:0] stored_code
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) stored_code <= CODE_FULL;
    else if (prog_valid)   stored_code <= prog_code;
  end
endmodule

// File: rtl/ssr_duty_avg.sv
`timescale 1ns/1ps
module ssr_duty_avg
  import ssr_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int AVG_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [DUTY_W-1:0] duty_pct,
  input  logic              duty_valid,
  output logic [CODE_W-1:0] duty_code
);
  localparam int SUM_W = DUTY_W + AVG_LOG2;
  localparam logic [DUTY_W-1:0] DUTY_MAX = DUTY_W'(100);

  logic [SUM_W-1:0]    acc;
  logic [AVG_LOG2-1:0] n_seen;
  logic [DUTY_W-1:0]   duty_clamped;
  logic [SUM_W-1:0]    group_sum;
  logic [SUM_W-1:0]    group_avg;
  logic [MV_W-1:0]     group_mv;
  logic                group_done;

  always_comb begin
    duty_clamped = (duty_pct > DUTY_MAX) ? DUTY_MAX : duty_pct;
    group_sum    = acc + SUM_W'(duty_clamped);
    group_avg    = group_sum >> AVG_LOG2;
    group_mv     = MV_W'(group_avg << 1);   // percent * 2 mV
    group_done   = duty_valid && (n_seen == '1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      acc       <= '0;
      n_seen    <= '0;
      duty_code <= CODE_FULL;
    end else if (duty_valid) begin
      if (group_done) begin
        duty_code <= mv_to_code(group_mv);
        acc       <= '0;
        n_seen    <= '0;
      end else begin
        acc    <= group_sum;
        n_seen <= n_seen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssr_ramp.sv
`timescale 1ns/1ps
module ssr_ramp
  import ssr_pkg::*;
#(
  parameter int STEP_CYCLES = 68200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [CODE_W-1:0] target_code,
  output logic [CODE_W-1:0] step_idx,
  output logic              ramping,
  output logic              step_tick,
  output logic              en_q
);
  localparam int CNT_W = $clog2(STEP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0]  dwell;
  logic [CODE_W-1:0] next_idx;

  assign step_tick = ramping && (dwell == CNT_LAST);
  assign next_idx  = step_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      step_idx <= '0;
      ramping  <= 1'b0;
      dwell    <= '0;
      en_q     <= 1'b0;
    end else begin
      en_q <= 1'b1;
      if (!en_q) begin
        ramping <= 1'b1;
        dwell   <= '0;
      end else if (ramping) begin
        if (step_idx >= target_code) begin
          step_idx <= target_code;
          ramping  <= 1'b0;
        end else if (step_tick) begin
          step_idx <= next_idx;
          dwell    <= '0;
          if (next_idx == target_code) ramping <= 1'b0;
        end else begin
          dwell <= dwell + 1'b1;
        end
      end else begin
        step_idx <= target_code;
      end
    end
  end
endmodule

// File: rtl/softstart_ref_seq.sv
`timescale 1ns/1ps
module softstart_ref_seq
  import ssr_pkg::*;
#(
  parameter int STEP_CYCLES = 68200,
  parameter int DUTY_W      = 8,
  parameter int AVG_LOG2    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              mode_serial,
  input  logic [CODE_W-1:0] prog_code,
  input  logic              prog_valid,
  input  logic [DUTY_W-1:0] duty_pct,
  input  logic              duty_valid,
  output logic [CODE_W-1:0] step_idx,
  output logic [MV_W-1:0]   ref_mv,
  output logic              ss_active,
  output logic              ilim_half
);
  logic [CODE_W-1:0] stored_code;
  logic [CODE_W-1:0] duty_code;
  logic [CODE_W-1:0] target_code;
  logic              step_tick;
  logic              en_q;

  ssr_code_store u_store (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .prog_code(prog_code), .prog_valid(prog_valid),
    .stored_code(stored_code)
  );

  ssr_duty_avg #(.DUTY_W(DUTY_W), .AVG_LOG2(AVG_LOG2)) u_duty (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .duty_pct(duty_pct), .duty_valid(duty_valid),
    .duty_code(duty_code)
  );

  assign target_code = mode_serial ? stored_code : duty_code;

  ssr_ramp #(.STEP_CYCLES(STEP_CYCLES)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .target_code(target_code),
    .step_idx(step_idx), .ramping(ss_active),
    .step_tick(step_tick), .en_q(en_q)
  );

  assign ref_mv    = code_to_mv(step_idx);
  assign ilim_half = ss_active;
endmodule

// File: rtl/softstart_ref_seq_chk.sv
`timescale 1ns/1ps
module softstart_ref_seq_chk
  import ssr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              en_q,
  input logic              ss_active,
  input logic              ilim_half,
  input logic              step_tick,
  input logic [CODE_W-1:0] step_idx,
  input logic [CODE_W-1:0] target_code,
  input logic [MV_W-1:0]   ref_mv
);
  p_shutdown_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (step_idx == '0 && !ss_active && !ilim_half));

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_active) |-> step_idx == '0);

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && ss_active && step_tick && step_idx < target_code)
      |=> step_idx == $past(step_idx) + 1'b1);

  p_dwell_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && en_q && ss_active && !step_tick && step_idx < target_code)
      |=> $stable(step_idx));

  p_flag_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ss_active) && $past(run_en)) |-> step_idx == $past(target_code));

  p_ilim_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ilim_half) && $past(run_en)) |-> step_idx == $past(target_code));

  p_mv_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mv <= MV_W'(200));

  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && en_q && !ss_active) |=> step_idx == $past(target_code));
endmodule

bind softstart_ref_seq softstart_ref_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .en_q(en_q),
  .ss_active(ss_active), .ilim_half(ilim_half), .step_tick(step_tick),
  .step_idx(step_idx), .target_code(target_code), .ref_mv(ref_mv)
);

// File: tb/softstart_ref_seq_tb.sv
`timescale 1ns/1ps
module softstart_ref_seq_tb;
  localparam int SC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       mode_serial = 1'b1;
  logic [4:0] prog_code = '0;
  logic       prog_valid = 1'b0;
  logic [7:0] duty_pct = '0;
  logic       duty_valid = 1'b0;
  logic [4:0] step_idx;
  logic [7:0] ref_mv;
  logic       ss_active;
  logic       ilim_half;

  always #2.5 clk = ~clk;

  softstart_ref_seq #(.STEP_CYCLES(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_serial(mode_serial),
    .prog_code(prog_code), .prog_valid(prog_valid),
    .duty_pct(duty_pct), .duty_valid(duty_valid),
    .step_idx(step_idx), .ref_mv(ref_mv),
    .ss_active(ss_active), .ilim_half(ilim_half)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Table built by accumulating per-step increments.
  function automatic int bmv(int c);
    int v = 0;
    for (int k = 1; k <= c; k++) begin
      if (k == 1)       v += 5;
      else if (k <= 12) v += 3;
      else if (k <= 23) v += 6;
      else              v += 12;
    end
    return v;
  endfunction

  function automatic int code_for(int mv);
    int r = 0;
    for (int c = 0; c < 32; c++) if (bmv(c) <= mv) r = c;
    return r;
  endfunction

  // Behavioural reference model.
  int m_idx, m_cnt, m_store, m_sum, m_n, m_dcode;
  bit m_ramp, m_prev;

  always @(posedge clk) begin
    int tgt;
    int d;
    if (!rst_n) begin
      m_idx = 0; m_ramp = 0; m_cnt = 0; m_store = 31;
      m_sum = 0; m_n = 0; m_dcode = 31; m_prev = 0;
    end else begin
      tgt = mode_serial ? m_store : m_dcode;
      if (!run_en) begin
        m_idx = 0; m_ramp = 0; m_cnt = 0; m_store = 31;
        m_sum = 0; m_n = 0; m_dcode = 31; m_prev = 0;
      end else begin
        if (!m_prev) begin
          m_ramp = 1; m_cnt = 0;
        end else if (m_ramp) begin
          if (m_idx >= tgt) begin
            m_idx = tgt; m_ramp = 0;
          end else if (m_cnt == SC - 1) begin
            m_idx++; m_cnt = 0;
            if (m_idx == tgt) m_ramp = 0;
          end else begin
            m_cnt++;
          end
        end else begin
          m_idx = tgt;
        end
        if (prog_valid) m_store = int'(prog_code);
        if (duty_valid) begin
          d = (int'(duty_pct) > 100) ? 100 : int'(duty_pct);
          m_sum += d; m_n++;
          if (m_n == 4) begin
            m_dcode = code_for(2 * (m_sum / 4));
            m_sum = 0; m_n = 0;
          end
        end
        m_prev = 1;
      end
    end
  end

  task automatic cmp();
    vectors++;
    if (int'(step_idx) != m_idx || int'(ref_mv) != bmv(m_idx) ||
        ss_active !== m_ramp || ilim_half !== m_ramp) begin
      miscompares++;
      $display("FAIL %s idx got %0d exp %0d, mv got %0d exp %0d, ss got %0b exp %0b, ilim got %0b exp %0b",
               cur_req, step_idx, m_idx, ref_mv, bmv(m_idx), ss_active, m_ramp, ilim_half, m_ramp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cmp();
    end
  endtask

  task automatic expect_eq(string req, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic prog(int c);
    prog_code = 5'(c); prog_valid = 1'b1;
    step(1);
    prog_valid = 1'b0;
  endtask

  task automatic feed(int d);
    duty_pct = 8'(d); duty_valid = 1'b1;
    step(1);
    duty_valid = 1'b0;
    step(1);
  endtask

  task automatic bounce(); // shutdown then re-enable
    run_en = 1'b0;
    step(3);
    run_en = 1'b1;
  endtask

  initial begin
    // R1: reset state
    step(3);
    expect_eq("R1", "idx in reset", int'(step_idx), 0);
    expect_eq("R1", "ss in reset", int'(ss_active), 0);
    rst_n = 1'b1;
    step(2);
    expect_eq("R1", "ilim while disabled", int'(ilim_half), 0);

    // R2/R3/R4: default ramp
    cur_req = "R2";
    run_en = 1'b1;
    step(1);
    expect_eq("R3", "ss at ramp start", int'(ss_active), 1);
    expect_eq("R2", "idx at ramp start", int'(step_idx), 0);
    step(SC * 5);
    expect_eq("R2", "idx after 5 intervals", int'(step_idx), 5);
    step(SC * 26 + 4);
    expect_eq("R4", "final idx", int'(step_idx), 31);
    expect_eq("R4", "final mv", int'(ref_mv), 200);
    expect_eq("R3", "ilim after ramp", int'(ilim_half), 0);

    // R5/R6: sweep every code
    cur_req = "R5";
    for (int c = 0; c < 32; c++) begin
      prog(c);
      step(2);
      expect_eq("R6", "idx follows code", int'(step_idx), c);
      expect_eq("R5", "table value", int'(ref_mv), bmv(c));
    end

    // R10: programmed code lost at shutdown
    cur_req = "R10";
    prog(7);
    step(3);
    bounce();
    step(SC * 31 + 6);
    expect_eq("R10", "idx after restart", int'(step_idx), 31);

    // R7: higher code mid-ramp
    cur_req = "R7";
    bounce();
    step(SC * 5 + 1);
    prog(20);
    expect_eq("R7", "ramp still active", int'(ss_active), 1);
    step(SC * 16);
    expect_eq("R7", "raised target reached", int'(step_idx), 20);
    expect_eq("R7", "ss after raised target", int'(ss_active), 0);

    // R7: lower code mid-ramp
    bounce();
    step(SC * 10);
    prog(3);
    step(2);
    expect_eq("R7", "lowered target", int'(step_idx), 3);
    expect_eq("R7", "ss after lowered target", int'(ss_active), 0);

    // R8/R9: duty mode
    cur_req = "R8";
    mode_serial = 1'b0;
    bounce();
    step(SC * 31 + 6);
    expect_eq("R8", "duty default", int'(step_idx), 31);
    feed(50); feed(50); feed(50); feed(50);
    expect_eq("R8", "50% duty", int'(step_idx), 22);
    feed(10); feed(20); feed(30); feed(40);
    expect_eq("R8", "mixed duty avg 25", int'(step_idx), 14);
    cur_req = "R9";
    feed(0); feed(0); feed(1); feed(2);
    expect_eq("R9", "sub-1% duty", int'(step_idx), 0);
    feed(150); feed(200); feed(100); feed(120);
    expect_eq("R9", "clamped duty", int'(step_idx), 31);
    feed(1); feed(1); feed(1); feed(1);
    expect_eq("R9", "1% duty", int'(step_idx), 0);
    feed(3); feed(3); feed(3); feed(3);
    expect_eq("R9", "3% duty", int'(step_idx), 1);

    cur_req = "R1";
    run_en = 1'b0;
    step(3);
    expect_eq("R1", "idx after shutdown", int'(step_idx), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog got hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule